// File: doc/BRIEF.md
# I2C Mode Event Logic for a Clocked Serial Unit

This block wraps a clock-synchronous serial shift unit and, under one mode input, turns it into a simple two-wire (I2C) engine. With the mode input low the wrapper is transparent: the shift unit's transmit-done and receive-done strobes pass straight to the interrupt and DMA outputs, the data bit goes to the SDA pad at once, and both pads are driven push-pull.

With the mode input high the pads become open-drain (a 1 releases the wire, a 0 pulls it low), the pad inputs pass through a wider glitch filter, and the interrupt and DMA outputs carry bus events instead of the shift unit's own strobes. The transmit interrupt reports a missing acknowledge on the ninth clock, the receive interrupt reports START or STOP, the DMA request reports a received acknowledge, and a separate interrupt reports either a bus collision or an acknowledge, picked by a select input. The SDA output level is held back by a fixed number of clocks after each falling SCL so that it never changes near the SCL edge. When serial operation is off, SDA rests at a programmable idle level. The filtered pad values are always available for read-back.

Top module: `sio_i2c_mode_wrap`

## Requirements
- R1: With `i2c_mode` low, `irq_tx` equals `tx_done_i`, `irq_rx` and `dma_req` both equal `rx_done_i` in the same cycle, and `irq_bc` stays low.
- R2: With `i2c_mode` high, `tx_done_i` and `rx_done_i` have no effect on any strobe output.
- R3: With `i2c_mode` high, `irq_rx` pulses for one cycle when `sda_rd` goes 1 to 0 (START) or 0 to 1 (STOP) while `scl_rd` has been high on this and the previous cycle.
- R4: With `i2c_mode` and `ser_en` high, `irq_tx` pulses for one cycle on a rising `scl_rd` while `bit_cnt_i` equals DATA_BITS+1 (the acknowledge slot, value 9 by default) and `sda_rd` is 1 (NACK).
- R5: Under the same condition as R4 but with `sda_rd` at 0 (ACK), `dma_req` pulses for one cycle; `irq_tx` and `dma_req` are never high together in this mode.
- R6: With `i2c_mode` and `ser_en` high, `bc_sel` at 0 makes `irq_bc` pulse on a rising `scl_rd` when `bit_cnt_i` is in 1..DATA_BITS, the block's own SDA level is 1 and `sda_rd` is 0 (collision); `bc_sel` at 1 makes `irq_bc` pulse on ACK instead.
- R7: With `i2c_mode` and `ser_en` high, the SDA level takes `tx_bit_i` exactly SDA_DLY_CLKS clock edges after `scl_rd` falls and not otherwise; with `i2c_mode` low it follows `tx_bit_i` in the same cycle.
- R8: A pad pulse shorter than FILT_I2C_CLKS clocks (10) never reaches `sda_rd`/`scl_rd` in I2C mode; in normal mode only pulses shorter than FILT_NORM_CLKS clocks (3) are removed.
- R9: With `i2c_mode` high, `sda_oe` is 1 exactly when the SDA level is 0 (and then `sda_o` is 0), and `scl_oe` is the inverse of `scl_clk_i`; with `i2c_mode` low both enables are 1.
- R10: With `ser_en` low, the SDA level equals `init_sda` (in I2C mode from the next clock edge).
- R11: After reset all strobe outputs are 0 and `scl_rd`, `sda_rd` read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2c_mode | input | 1 | 1 selects I2C behaviour, 0 transparent serial mode |
| ser_en | input | 1 | Serial operation enabled |
| init_sda | input | 1 | SDA idle level while serial operation is off |
| bc_sel | input | 1 | Source of `irq_bc`: 0 collision, 1 acknowledge |
| scl_pad_i | input | 1 | Raw SCL pad input |
| sda_pad_i | input | 1 | Raw SDA pad input |
| scl_clk_i | input | 1 | Shift unit's serial clock level |
| tx_bit_i | input | 1 | Shift unit's current transmit bit |
| bit_cnt_i | input | CNT_W (4) | Bit position on the bus, 1..DATA_BITS data, DATA_BITS+1 acknowledge |
| tx_done_i | input | 1 | Shift unit transmit-complete strobe |
| rx_done_i | input | 1 | Shift unit receive-complete strobe |
| scl_o | output | 1 | SCL output level |
| scl_oe | output | 1 | SCL pad drive enable |
| sda_o | output | 1 | SDA output level |
| sda_oe | output | 1 | SDA pad drive enable |
| scl_rd | output | 1 | Filtered SCL read-back |
| sda_rd | output | 1 | Filtered SDA read-back |
| irq_tx | output | 1 | Transmit-slot interrupt strobe |
| irq_rx | output | 1 | Receive-slot interrupt strobe |
| irq_bc | output | 1 | Collision/acknowledge interrupt strobe |
| dma_req | output | 1 | DMA request strobe |

## Verification
The bench builds the block with its default parameters: 8 data bits, two synchronizer stages, a 10-clock filter in I2C mode and a 3-clock filter in normal mode (50 ns and 15 ns at 200 MHz), and a 4-clock SDA delay with the delay variant enabled. A 6-clock SDA pulse falls between the two filter widths, so the same stimulus shows the pulse passing in normal mode and vanishing in I2C mode. Because the SDA delay is shorter than the I2C filter width, a full byte with START, data, ACK, NACK, a forced collision and STOP can be clocked through with a wide margin, and the delay can be counted edge by edge against the filtered SCL.

// File: rtl/sio_i2c_pkg.sv
package sio_i2c_pkg;

   // One cycle worth of decoded bus events
   typedef struct packed {
      logic start;
      logic stop;
      logic ack;
      logic nack;
      logic coll;
   } bus_evt_t;

   localparam bus_evt_t EVT_NONE = '{default: 1'b0};

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int bits_for(input int value);
      return (value < 2) ? 1 : $clog2(value + 1);
   endfunction

endpackage

// File: rtl/sio_i2c_glitch_filter.sv
module sio_i2c_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int LEN_WIDE    = 10,
   parameter int LEN_NARROW  = 3,
   parameter bit RST_LEVEL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wide_sel,
   input  logic pad_i,
   output logic filt_o
);
   import sio_i2c_pkg::*;

   localparam int LEN_MAX = max_of(LEN_WIDE, LEN_NARROW);
   localparam int CW      = bits_for(LEN_MAX);
   localparam logic [CW-1:0] LIM_WIDE   = CW'(LEN_WIDE - 1);
   localparam logic [CW-1:0] LIM_NARROW = CW'(LEN_NARROW - 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("sio_i2c_glitch_filter: SYNC_STAGES must be at least 1");
   end
   if (LEN_WIDE < 1 || LEN_NARROW < 1) begin : g_bad_len
      $error("sio_i2c_glitch_filter: filter lengths must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_lvl;

   // Synchronizer chain, one stage per generate step
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= RST_LEVEL;
            else        sync_q[0] <= pad_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= RST_LEVEL;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign sync_lvl = sync_q[SYNC_STAGES-1];

   logic [CW-1:0] run_cnt;
   logic [CW-1:0] limit;
   logic          level_q;

   always_comb begin
      limit = wide_sel ? LIM_WIDE : LIM_NARROW;
   end

   // Output flips only after LEN consecutive differing samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= RST_LEVEL;
         run_cnt <= '0;
      end else if (sync_lvl == level_q) begin
         run_cnt <= '0;
      end else if (run_cnt >= limit) begin
         level_q <= sync_lvl;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   assign filt_o = level_q;

endmodule

// File: rtl/sio_i2c_bus_events.sv
module sio_i2c_bus_events #(
   parameter int DATA_BITS = 8,
   parameter int CNT_W     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_f,
   input  logic                  sda_f,
   input  logic                  ser_en,
   input  logic                  own_sda,
   input  logic [CNT_W-1:0]      bit_cnt,
   output logic                  scl_fall,
   output sio_i2c_pkg::bus_evt_t evt
);
   import sio_i2c_pkg::*;

   localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_BITS + 1);
   localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(1);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_BITS);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   logic scl_rise;
   logic scl_steady_hi;
   logic in_ack_slot;
   logic in_data_slot;

   always_comb begin
      scl_rise      = scl_f & ~scl_q;
      scl_fall      = ~scl_f & scl_q;
      scl_steady_hi = scl_f & scl_q;
      in_ack_slot   = (bit_cnt == ACK_SLOT);
      in_data_slot  = (bit_cnt >= FIRST_BIT) && (bit_cnt <= LAST_BIT);
   end

   always_comb begin
      evt       = EVT_NONE;
      evt.start = scl_steady_hi & sda_q & ~sda_f;
      evt.stop  = scl_steady_hi & ~sda_q & sda_f;
      evt.ack   = scl_rise & ser_en & in_ack_slot & ~sda_f;
      evt.nack  = scl_rise & ser_en & in_ack_slot & sda_f;
      evt.coll  = scl_rise & ser_en & in_data_slot & own_sda & ~sda_f;
   end

endmodule

// File: rtl/sio_i2c_sda_delay.sv
module sio_i2c_sda_delay #(
   parameter bit DELAY_EN = 1'b1,
   parameter int DLY_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic i2c_mode,
   input  logic ser_en,
   input  logic tx_bit,
   input  logic init_lvl,
   input  logic scl_fall,
   output logic sda_lvl
);
   import sio_i2c_pkg::*;

   localparam int DW = bits_for(DLY_CLKS);
   localparam logic [DW-1:0] DLY_LOAD = DW'(DLY_CLKS - 1);

   logic desired;
   assign desired = ser_en ? tx_bit : init_lvl;

   if (!DELAY_EN) begin : g_direct
      // No hold-off variant: level follows the source in both modes
      assign sda_lvl = desired;
   end else begin : g_delayed
      if (DLY_CLKS < 2) begin : g_bad_dly
         $error("sio_i2c_sda_delay: DLY_CLKS must be at least 2");
      end

      logic          held;
      logic          armed;
      logic [DW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held  <= 1'b1;
            armed <= 1'b0;
            cnt   <= '0;
         end else if (!i2c_mode || !ser_en) begin
            held  <= desired;
            armed <= 1'b0;
         end else if (scl_fall) begin
            armed <= 1'b1;
            cnt   <= DLY_LOAD;
         end else if (armed) begin
            if (cnt == DW'(1)) begin
               held  <= tx_bit;
               armed <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end

      assign sda_lvl = i2c_mode ? held : desired;
   end

endmodule

// File: rtl/sio_i2c_mode_wrap.sv
module sio_i2c_mode_wrap #(
   parameter int DATA_BITS      = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int FILT_I2C_CLKS  = 10,
   parameter int FILT_NORM_CLKS = 3,
   parameter bit OUT_DELAY_EN   = 1'b1,
   parameter int SDA_DLY_CLKS   = 4,
   parameter int CNT_W          = $clog2(DATA_BITS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i2c_mode,
   input  logic             ser_en,
   input  logic             init_sda,
   input  logic             bc_sel,
   input  logic             scl_pad_i,
   input  logic             sda_pad_i,
   input  logic             scl_clk_i,
   input  logic             tx_bit_i,
   input  logic [CNT_W-1:0] bit_cnt_i,
   input  logic             tx_done_i,
   input  logic             rx_done_i,
   output logic             scl_o,
   output logic             scl_oe,
   output logic             sda_o,
   output logic             sda_oe,
   output logic             scl_rd,
   output logic             sda_rd,
   output logic             irq_tx,
   output logic             irq_rx,
   output logic             irq_bc,
   output logic             dma_req
);
   import sio_i2c_pkg::*;

   if (DATA_BITS < 1) begin : g_bad_bits
      $error("sio_i2c_mode_wrap: DATA_BITS must be at least 1");
   end
   if (CNT_W < $clog2(DATA_BITS + 2)) begin : g_bad_cnt
      $error("sio_i2c_mode_wrap: CNT_W cannot hold the acknowledge slot");
   end
   if (OUT_DELAY_EN && SDA_DLY_CLKS >= FILT_I2C_CLKS) begin : g_bad_ratio
      $error("sio_i2c_mode_wrap: SDA delay must be shorter than the I2C filter");
   end

   // ---------------- input filtering ----------------
   logic scl_f;
   logic sda_f;

   sio_i2c_glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .LEN_WIDE    (FILT_I2C_CLKS),
      .LEN_NARROW  (FILT_NORM_CLKS),
      .RST_LEVEL   (1'b1)
   ) scl_filt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide_sel (i2c_mode),
      .pad_i    (scl_pad_i),
      .filt_o   (scl_f)
   );

   sio_i2c_glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .LEN_WIDE    (FILT_I2C_CLKS),
      .LEN_NARROW  (FILT_NORM_CLKS),
      .RST_LEVEL   (1'b1)
   ) sda_filt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide_sel (i2c_mode),
      .pad_i    (sda_pad_i),
      .filt_o   (sda_f)
   );

   // ---------------- SDA output timing ----------------
   logic     sda_lvl;
   logic     scl_fall;
   bus_evt_t evt;

   sio_i2c_sda_delay #(
      .DELAY_EN (OUT_DELAY_EN),
      .DLY_CLKS (SDA_DLY_CLKS)
   ) sda_dly_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .i2c_mode (i2c_mode),
      .ser_en   (ser_en),
      .tx_bit   (tx_bit_i),
      .init_lvl (init_sda),
      .scl_fall (scl_fall),
      .sda_lvl  (sda_lvl)
   );

   // ---------------- bus event decode ----------------
   sio_i2c_bus_events #(
      .DATA_BITS (DATA_BITS),
      .CNT_W     (CNT_W)
   ) events_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .ser_en   (ser_en),
      .own_sda  (sda_lvl),
      .bit_cnt  (bit_cnt_i),
      .scl_fall (scl_fall),
      .evt      (evt)
   );

   // ---------------- source routing ----------------
   always_comb begin
      if (i2c_mode) begin
         irq_tx  = evt.nack;
         irq_rx  = evt.start | evt.stop;
         dma_req = evt.ack;
         irq_bc  = bc_sel ? evt.ack : evt.coll;
      end else begin
         irq_tx  = tx_done_i;
         irq_rx  = rx_done_i;
         dma_req = rx_done_i;
         irq_bc  = 1'b0;
      end
   end

   // ---------------- pad drive ----------------
   always_comb begin
      scl_o  = scl_clk_i;
      sda_o  = sda_lvl;
      scl_oe = i2c_mode ? ~scl_clk_i : 1'b1;
      sda_oe = i2c_mode ? ~sda_lvl   : 1'b1;
   end

   assign scl_rd = scl_f;
   assign sda_rd = sda_f;

endmodule

// File: rtl/sio_i2c_mode_wrap_chk.sv
module sio_i2c_mode_wrap_chk (
   input logic clk,
   input logic rst_n,
   input logic i2c_mode,
   input logic ser_en,
   input logic tx_done_i,
   input logic rx_done_i,
   input logic scl_clk_i,
   input logic scl_oe,
   input logic sda_o,
   input logic sda_oe,
   input logic scl_rd,
   input logic irq_tx,
   input logic irq_rx,
   input logic irq_bc,
   input logic dma_req
);

   // R1: normal mode passes the shift unit's strobes through
   assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_mode |-> (irq_tx == tx_done_i) && (irq_rx == rx_done_i) && (dma_req == rx_done_i));

   // R3: START/STOP strobe only while SCL reads high
   assert_rx_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (i2c_mode && irq_rx) |-> scl_rd);

   // R4: NACK strobe only at a high SCL
   assert_nack_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (i2c_mode && irq_tx) |-> scl_rd);

   // R5: ACK and NACK never reported together
   assert_ack_nack_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      i2c_mode |-> !(irq_tx && dma_req));

   // R6: no collision/ack interrupt in normal mode
   assert_bc_quiet_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_mode |-> !irq_bc);

   // R7: SDA holds while SCL stays high in I2C mode
   assert_sda_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (i2c_mode && $past(i2c_mode) && ser_en && $past(ser_en) && scl_rd && $past(scl_rd))
      |-> $stable(sda_o));

   // R9: open drain never drives a high level, SCL enable inverts the clock
   assert_open_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      i2c_mode |-> (!sda_oe || !sda_o) && (scl_oe == !scl_clk_i));

endmodule

bind sio_i2c_mode_wrap sio_i2c_mode_wrap_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .i2c_mode  (i2c_mode),
   .ser_en    (ser_en),
   .tx_done_i (tx_done_i),
   .rx_done_i (rx_done_i),
   .scl_clk_i (scl_clk_i),
   .scl_oe    (scl_oe),
   .sda_o     (sda_o),
   .sda_oe    (sda_oe),
   .scl_rd    (scl_rd),
   .irq_tx    (irq_tx),
   .irq_rx    (irq_rx),
   .irq_bc    (irq_bc),
   .dma_req   (dma_req)
);

// File: tb/sio_i2c_mode_wrap_tb_top.sv
`timescale 1ns/1ps
module sio_i2c_mode_wrap_tb_top;

   localparam int  DATA_BITS = 8;
   localparam int  CNT_W     = $clog2(DATA_BITS + 2);
   localparam int  SDA_DLY   = 4;
   localparam real HALF_CLK  = 2.5;   // 200 MHz

   localparam int EV_TX  = 1;
   localparam int EV_RX  = 2;
   localparam int EV_DMA = 3;
   localparam int EV_BC  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i2c_mode = 1'b1, ser_en = 1'b0, init_sda = 1'b1, bc_sel = 1'b0;
   logic scl_clk = 1'b1, tx_bit = 1'b1, tx_done = 1'b0, rx_done = 1'b0;
   logic slave_sda = 1'b1, glitch_n = 1'b1;
   logic [CNT_W-1:0] bit_cnt = '0;

   logic scl_o, scl_oe, sda_o, sda_oe, scl_rd, sda_rd;
   logic irq_tx, irq_rx, irq_bc, dma_req;
   logic dut_lvl, sda_pad;

   always #(HALF_CLK) clk = ~clk;

   assign dut_lvl = sda_oe ? sda_o : 1'b1;
   assign sda_pad = dut_lvl & slave_sda & glitch_n;

   sio_i2c_mode_wrap dut_i (
      .clk (clk), .rst_n (rst_n), .i2c_mode (i2c_mode), .ser_en (ser_en),
      .init_sda (init_sda), .bc_sel (bc_sel), .scl_pad_i (scl_clk),
      .sda_pad_i (sda_pad), .scl_clk_i (scl_clk), .tx_bit_i (tx_bit),
      .bit_cnt_i (bit_cnt), .tx_done_i (tx_done), .rx_done_i (rx_done),
      .scl_o (scl_o), .scl_oe (scl_oe), .sda_o (sda_o), .sda_oe (sda_oe),
      .scl_rd (scl_rd), .sda_rd (sda_rd), .irq_tx (irq_tx), .irq_rx (irq_rx),
      .irq_bc (irq_bc), .dma_req (dma_req)
   );

   int vectors = 0;
   int miscompares = 0;
   int strobe_cnt = 0;
   bit finished = 1'b0;
   int    exp_code[$];
   string exp_req[$];

   function automatic string ev_name(input int c);
      case (c)
         EV_TX:   return "irq_tx";
         EV_RX:   return "irq_rx";
         EV_DMA:  return "dma_req";
         EV_BC:   return "irq_bc";
         default: return "none";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(input int code, input string req);
      exp_code.push_back(code);
      exp_req.push_back(req);
   endtask

   // Scoreboard monitor: pops one expected item per observed strobe
   task automatic sb_take(input int got);
      int    e;
      string r;
      vectors++;
      if (exp_code.size() == 0) begin
         miscompares++;
         $display("FAIL R2 unexpected strobe: actual %s expected none", ev_name(got));
      end else begin
         e = exp_code.pop_front();
         r = exp_req.pop_front();
         if (e != got) begin
            miscompares++;
            $display("FAIL %s event order: actual %s expected %s", r, ev_name(got), ev_name(e));
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (irq_tx)  sb_take(EV_TX);
         if (irq_rx)  sb_take(EV_RX);
         if (dma_req) sb_take(EV_DMA);
         if (irq_bc)  sb_take(EV_BC);
         if (irq_tx || irq_rx || dma_req || irq_bc) strobe_cnt++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // Pulse SDA low for n clocks, report whether the filtered read-back dipped
   task automatic sda_glitch(input int n, output bit seen_low);
      seen_low = 1'b0;
      for (int i = 0; i < n + 24; i++) begin
         @(negedge clk);
         glitch_n = (i < n) ? 1'b0 : 1'b1;
         if (!sda_rd) seen_low = 1'b1;
      end
   endtask

   // One byte plus acknowledge slot; coll_bit forces the slave low on that bit
   task automatic send_byte(input logic [7:0] data, input bit slave_ack,
                            input int coll_bit, input int measure_bit);
      int n;
      for (int k = 1; k <= DATA_BITS + 1; k++) begin
         scl_clk = 1'b0;
         bit_cnt = CNT_W'(k);
         tx_bit  = (k <= DATA_BITS) ? data[DATA_BITS - k] : 1'b1;
         tick(3);
         if (k == DATA_BITS + 1) slave_sda = !slave_ack;
         else                    slave_sda = (k == coll_bit) ? 1'b0 : 1'b1;
         if (k == coll_bit) expect_ev(EV_BC, "R6");
         if (k == DATA_BITS + 1) begin
            if (!slave_ack)  expect_ev(EV_TX, "R4");
            else begin
               expect_ev(EV_DMA, "R5");
               if (bc_sel) expect_ev(EV_BC, "R6");
            end
         end
         if (k == measure_bit) begin
            n = 0;
            @(negedge clk);
            while (scl_rd) @(negedge clk);
            check(scl_oe == 1'b1, "R9", "scl_oe while SCL low", scl_oe, 1);
            while (dut_lvl != tx_bit && n < 100) begin
               @(negedge clk);
               n++;
            end
            check(n == SDA_DLY, "R7", "SDA delay after SCL fall (clocks)", n, SDA_DLY);
         end
         tick(30);
         scl_clk = 1'b1;
         tick(30);
      end
   endtask

   initial begin
      bit seen;
      int base;
      tick(5);
      rst_n = 1'b1;
      tick(20);
      @(negedge clk);
      // R11: reset state
      check(!(irq_tx || irq_rx || irq_bc || dma_req), "R11", "strobes after reset", 1, 0);
      check(scl_rd && sda_rd, "R11", "read-back after reset", {scl_rd, sda_rd}, 3);
      check(sda_oe == 1'b0, "R10", "SDA released at idle level 1", sda_oe, 0);

      // ---- normal mode ----
      i2c_mode = 1'b0;
      tick(20);
      check(scl_oe && sda_oe, "R9", "push-pull enables in normal mode", {scl_oe, sda_oe}, 3);
      ser_en = 1'b1;
      tx_bit = 1'b0;
      #0.5;
      check(sda_o == 1'b0, "R7", "undelayed SDA in normal mode", sda_o, 0);
      tx_bit = 1'b1;
      tick(2);
      expect_ev(EV_TX, "R1");
      tx_done = 1'b1; tick(1); tx_done = 1'b0;
      tick(3);
      expect_ev(EV_RX, "R1");
      expect_ev(EV_DMA, "R1");
      rx_done = 1'b1; tick(1); rx_done = 1'b0;
      tick(5);
      sda_glitch(6, seen);
      check(seen == 1'b1, "R8", "6-clock pulse passes narrow filter", seen, 1);
      ser_en = 1'b0;
      tick(20);

      // ---- I2C mode ----
      i2c_mode = 1'b1;
      tick(30);
      sda_glitch(6, seen);
      check(seen == 1'b0, "R8", "6-clock pulse removed by wide filter", seen, 0);
      base = strobe_cnt;
      tx_done = 1'b1; rx_done = 1'b1;
      tick(3);
      tx_done = 1'b0; rx_done = 1'b0;
      tick(3);
      check(strobe_cnt == base, "R2", "strobes from shift unit in I2C mode", strobe_cnt - base, 0);

      // START via idle level going low while SCL high
      expect_ev(EV_RX, "R3");
      init_sda = 1'b0;
      tick(30);
      check(sda_oe == 1'b1 && sda_o == 1'b0, "R10", "SDA pulled to idle level 0", sda_oe, 1);
      ser_en = 1'b1;
      tick(5);

      bc_sel = 1'b0;
      send_byte(8'hA5, 1'b1, -1, 2);
      bc_sel = 1'b1;
      send_byte(8'h3C, 1'b1, -1, -1);
      bc_sel = 1'b0;
      send_byte(8'hFF, 1'b0, -1, -1);
      send_byte(8'hF0, 1'b1, 2, -1);

      // STOP: pull low during SCL low, release while SCL high
      scl_clk = 1'b0;
      tick(3);
      slave_sda = 1'b1;
      ser_en    = 1'b0;
      init_sda  = 1'b0;
      tick(30);
      scl_clk = 1'b1;
      tick(30);
      expect_ev(EV_RX, "R3");
      init_sda = 1'b1;
      tick(40);
      check(sda_oe == 1'b0, "R9", "SDA released after STOP", sda_oe, 0);
      check(exp_code.size() == 0, "R3", "expected events left unseen", exp_code.size(), 0);
      finish_run();
   end

   initial begin
      #(HALF_CLK * 2 * 150000);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule